// File: doc/BRIEF.md
# Safe Write-Protect and Indicator Controller

This block decides when a flash array may be write-protected and drives the two board status indicators that go with it. A debounced switch asks for protection by going low. A configuration bit can switch the whole protection feature off. The storage engine supplies two busy inputs: a data transfer is in flight, and internal operations are still outstanding. The block never applies or lifts protection while either one is high. A switch change that arrives while the engine is busy is remembered, and it takes effect on the first idle cycle, so no write is cut short.

When protection is in force, the block drives the flash write-protect output low. It also raises a status flag for the host side and blocks writes to the configuration area. A configuration-area write that arrives in this state raises an error pulse. A write that arrives while protection is still waiting for the engine to go idle is allowed. Two active-low indicators are modelled as an output enable with a constant low data value, so that high-Z can be shown. One indicator shows data activity. The other shows that the device is powered and initialized.

The reset input is asynchronous and active low. Its release passes through a synchronizer inside the block.

Top module: `wp_safe_ctrl`

## Requirements
- R1: With protection enabled and both busy inputs low, a low switch level makes `flash_wp_n` low one clock edge later.
- R2: `host_wp` is high exactly while protection is in force, so it always equals the inverse of `flash_wp_n`.
- R3: While protection is in force, `cfgwr_block` is high. A `cfgwr_req` that is sampled in that state gives a one-cycle high pulse on `cfgwr_err` after the same edge.
- R4: A `cfgwr_req` that is sampled while protection is requested but not yet applied gives no error (`cfgwr_err` stays low).
- R5: Protection is not applied on any edge at which `xfer_busy` or `ops_pending` is high. It is applied on the first edge at which both are low and the request still holds.
- R6: Protection is lifted one edge after the switch returns high if both busy inputs are low. Otherwise it is lifted on the first edge at which both are low.
- R7: While `wp_enable` is low, a low switch level never applies protection. Clearing `wp_enable` while protected counts as a release request under R6.
- R8: `act_led_oe` equals `xfer_busy` delayed by one edge, and `act_led_o` is always 0.
- R9: `rdy_led_oe` equals `init_done` delayed by one edge, and `rdy_led_o` is always 0.
- R10: During reset and for two edges after `rst_n` rises, the outputs are as follows: `flash_wp_n` is 1, every other output is 0, and the inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_sw_n | input | 1 | Debounced switch, low requests protection |
| wp_enable | input | 1 | Protection feature enable from configuration |
| xfer_busy | input | 1 | Data transfer in flight |
| ops_pending | input | 1 | Internal operations outstanding |
| init_done | input | 1 | Device powered and initialized |
| cfgwr_req | input | 1 | Write attempt to the configuration area |
| flash_wp_n | output | 1 | Flash write-protect, low protects |
| host_wp | output | 1 | Medium reported write-protected |
| cfgwr_block | output | 1 | Configuration-area writes refused |
| cfgwr_err | output | 1 | Refused write pulse |
| act_led_oe | output | 1 | Activity indicator drive enable |
| act_led_o | output | 1 | Activity indicator data (constant 0) |
| rdy_led_oe | output | 1 | Ready indicator drive enable |
| rdy_led_o | output | 1 | Ready indicator data (constant 0) |

## Verification
Every result in this block is due one clock edge after the inputs that cause it are sampled:
- protection changes, the status flag and the block flag,
- the error pulse,
- both indicator enables.

The one exception is the protection change: it waits for an edge at which both busy inputs are low. Leaving reset adds two more edges before any input is sampled.

The bench drives inputs just after the falling edge and updates its own behavioural model on the rising edge. It compares all outputs on the next falling edge, so each value is checked in the very cycle it becomes due. Directed sequences hold the busy inputs high across switch changes, including a switch pulse that ends before the engine goes idle. A long pseudo-random phase follows them.

// File: rtl/wp_safe_pkg.sv
package wp_safe_pkg;

  typedef enum logic [1:0] {
    WPS_OPEN    = 2'd0,
    WPS_ARMING  = 2'd1,
    WPS_ON      = 2'd2,
    WPS_DISARM  = 2'd3
  } wps_state_e;

  localparam int unsigned IND_ACT = 0;
  localparam int unsigned IND_RDY = 1;
  localparam int unsigned IND_NUM = 2;

  function automatic logic wps_protected(input wps_state_e s);
    return (s == WPS_ON) || (s == WPS_DISARM);
  endfunction

endpackage

// File: rtl/wps_rst_sync.sv
module wps_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  localparam int unsigned W = (STAGES < 1) ? 1 : STAGES;

  logic [W-1:0] chain_q;
  logic [W-1:0] chain_d;

  generate
    if (W == 1) begin : g_one
      assign chain_d = 1'b1;
    end else begin : g_many
      assign chain_d = {chain_q[W-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[W-1];
endmodule

// File: rtl/wps_sequencer.sv
module wps_sequencer
  import wp_safe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       busy,
  output logic       prot,
  output wps_state_e state
);
  wps_state_e st_q;
  wps_state_e st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      WPS_OPEN: begin
        if (req) st_d = busy ? WPS_ARMING : WPS_ON;
      end
      WPS_ARMING: begin
        if (!req)      st_d = WPS_OPEN;
        else if (!busy) st_d = WPS_ON;
      end
      WPS_ON: begin
        if (!req) st_d = busy ? WPS_DISARM : WPS_OPEN;
      end
      WPS_DISARM: begin
        if (req)        st_d = WPS_ON;
        else if (!busy) st_d = WPS_OPEN;
      end
      default: st_d = WPS_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WPS_OPEN;
    else        st_q <= st_d;
  end

  assign prot  = wps_protected(st_q);
  assign state = st_q;
endmodule

// File: rtl/wps_write_gate.sv
module wps_write_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic prot,
  input  logic wr_req,
  output logic block,
  output logic err
);
  logic err_q;
  logic err_d;
  logic err_en;

  always_comb begin
    err_d  = wr_req & prot;
    err_en = err_d | err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign block = prot;
  assign err   = err_q;
endmodule

// File: rtl/wps_indicators.sv
module wps_indicators #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] drive_req,
  output logic [N-1:0] oe,
  output logic [N-1:0] dat
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_ind
      logic oe_q;
      logic oe_en;
      assign oe_en = drive_req[i] ^ oe_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     oe_q <= 1'b0;
        else if (oe_en) oe_q <= drive_req[i];
      end
      assign oe[i]  = oe_q;
      assign dat[i] = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/wp_safe_ctrl.sv
module wp_safe_ctrl
  import wp_safe_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_sw_n,
  input  logic wp_enable,
  input  logic xfer_busy,
  input  logic ops_pending,
  input  logic init_done,
  input  logic cfgwr_req,
  output logic flash_wp_n,
  output logic host_wp,
  output logic cfgwr_block,
  output logic cfgwr_err,
  output logic act_led_oe,
  output logic act_led_o,
  output logic rdy_led_oe,
  output logic rdy_led_o
);
  logic             srst_n;
  logic             prot_req;
  logic             eng_busy;
  logic             prot;
  wps_state_e       seq_state;
  logic [IND_NUM-1:0] ind_req;
  logic [IND_NUM-1:0] ind_oe;
  logic [IND_NUM-1:0] ind_dat;

  wps_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign prot_req = wp_enable & ~wp_sw_n;
  assign eng_busy = xfer_busy | ops_pending;

  wps_sequencer u_seq (
    .clk   (clk),
    .rst_n (srst_n),
    .req   (prot_req),
    .busy  (eng_busy),
    .prot  (prot),
    .state (seq_state)
  );

  wps_write_gate u_gate (
    .clk    (clk),
    .rst_n  (srst_n),
    .prot   (prot),
    .wr_req (cfgwr_req),
    .block  (cfgwr_block),
    .err    (cfgwr_err)
  );

  always_comb begin
    ind_req          = '0;
    ind_req[IND_ACT] = xfer_busy;
    ind_req[IND_RDY] = init_done;
  end

  wps_indicators #(.N(IND_NUM)) u_ind (
    .clk       (clk),
    .rst_n     (srst_n),
    .drive_req (ind_req),
    .oe        (ind_oe),
    .dat       (ind_dat)
  );

  assign flash_wp_n = ~prot;
  assign host_wp    = (seq_state == WPS_ON) || (seq_state == WPS_DISARM);
  assign act_led_oe = ind_oe[IND_ACT];
  assign act_led_o  = ind_dat[IND_ACT];
  assign rdy_led_oe = ind_oe[IND_RDY];
  assign rdy_led_o  = ind_dat[IND_RDY];
endmodule

// File: rtl/wp_safe_ctrl_chk.sv
module wp_safe_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic wp_sw_n,
  input logic wp_enable,
  input logic xfer_busy,
  input logic ops_pending,
  input logic init_done,
  input logic cfgwr_req,
  input logic flash_wp_n,
  input logic host_wp,
  input logic cfgwr_block,
  input logic cfgwr_err,
  input logic act_led_oe,
  input logic act_led_o,
  input logic rdy_led_oe,
  input logic rdy_led_o
);
  p_apply_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_enable && !wp_sw_n && !xfer_busy && !ops_pending) |=> !flash_wp_n);

  p_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_wp == !flash_wp_n);

  p_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgwr_req && !flash_wp_n) |=> cfgwr_err);

  p_pend_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgwr_req && !cfgwr_block) |=> !cfgwr_err);

  p_defer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_wp_n && (xfer_busy || ops_pending)) |=> flash_wp_n);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_wp_n && (xfer_busy || ops_pending)) |=> !flash_wp_n);

  p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_enable && flash_wp_n) |=> flash_wp_n);

  p_act_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |=> act_led_oe);

  p_act_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_busy |=> !act_led_oe);

  p_rdy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> rdy_led_oe);

  p_rdy_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |=> !rdy_led_oe);

  always_comb begin
    a_led_low_r8: assert (act_led_o == 1'b0 && rdy_led_o == 1'b0);
  end
endmodule

bind wp_safe_ctrl wp_safe_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (srst_n),
  .wp_sw_n     (wp_sw_n),
  .wp_enable   (wp_enable),
  .xfer_busy   (xfer_busy),
  .ops_pending (ops_pending),
  .init_done   (init_done),
  .cfgwr_req   (cfgwr_req),
  .flash_wp_n  (flash_wp_n),
  .host_wp     (host_wp),
  .cfgwr_block (cfgwr_block),
  .cfgwr_err   (cfgwr_err),
  .act_led_oe  (act_led_oe),
  .act_led_o   (act_led_o),
  .rdy_led_oe  (rdy_led_oe),
  .rdy_led_o   (rdy_led_o)
);

// File: tb/wp_safe_ctrl_test.sv
`timescale 1ns/1ps
module wp_safe_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_sw_n = 1'b1, wp_enable = 1'b1, xfer_busy = 1'b0, ops_pending = 1'b0;
  logic init_done = 1'b0, cfgwr_req = 1'b0;
  logic flash_wp_n, host_wp, cfgwr_block, cfgwr_err;
  logic act_led_oe, act_led_o, rdy_led_oe, rdy_led_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;
  bit cmp_en = 1'b0;

  always #2 clk = ~clk;

  wp_safe_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wp_sw_n(wp_sw_n), .wp_enable(wp_enable),
    .xfer_busy(xfer_busy), .ops_pending(ops_pending), .init_done(init_done),
    .cfgwr_req(cfgwr_req), .flash_wp_n(flash_wp_n), .host_wp(host_wp),
    .cfgwr_block(cfgwr_block), .cfgwr_err(cfgwr_err), .act_led_oe(act_led_oe),
    .act_led_o(act_led_o), .rdy_led_oe(rdy_led_oe), .rdy_led_o(rdy_led_o)
  );

  // Behavioural reference model
  int  m_wait;
  bit  m_prot, m_err, m_act, m_rdy;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wait = 0; m_prot = 0; m_err = 0; m_act = 0; m_rdy = 0;
    end else if (m_wait < 2) begin
      m_wait = m_wait + 1;
    end else begin
      m_err = cfgwr_req && m_prot;
      if (!(xfer_busy || ops_pending)) m_prot = wp_enable && !wp_sw_n;
      m_act = xfer_busy;
      m_rdy = init_done;
    end
  end

  task automatic chk(input string tag, input logic got, input logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cmp_en) begin
      chk("R1 flash_wp_n model", flash_wp_n, !m_prot);
      chk("R2 host_wp model", host_wp, m_prot);
      chk("R3 cfgwr_block model", cfgwr_block, m_prot);
      chk("R3 cfgwr_err model", cfgwr_err, m_err);
      chk("R8 act_led_oe model", act_led_oe, m_act);
      chk("R8 act_led_o", act_led_o, 1'b0);
      chk("R9 rdy_led_oe model", rdy_led_oe, m_rdy);
      chk("R9 rdy_led_o", rdy_led_o, 1'b0);
    end
  end

  // advance one cycle: inputs set just after a falling edge, result due at the next one
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #0.5;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    while (cycles < 100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    step(3);
    // R10: inputs active during reset have no effect
    wp_sw_n = 0; xfer_busy = 1; init_done = 1; cfgwr_req = 1;
    step(2);
    chk("R10 flash_wp_n in reset", flash_wp_n, 1'b1);
    chk("R10 act_led_oe in reset", act_led_oe, 1'b0);
    wp_sw_n = 1; xfer_busy = 0; init_done = 0; cfgwr_req = 0;
    rst_n = 1'b1;
    step(2);
    chk("R10 host_wp after release", host_wp, 1'b0);
    chk("R10 cfgwr_err after release", cfgwr_err, 1'b0);
    chk("R10 rdy_led_oe after release", rdy_led_oe, 1'b0);
    step(1);
    cmp_en = 1'b1;

    // R1/R2/R3: protect while idle, then reject a write
    wp_sw_n = 0;
    step(1);
    chk("R1 applied when idle", flash_wp_n, 1'b0);
    chk("R2 status raised", host_wp, 1'b1);
    chk("R3 block raised", cfgwr_block, 1'b1);
    cfgwr_req = 1;
    step(1);
    cfgwr_req = 0;
    chk("R3 error pulse", cfgwr_err, 1'b1);
    step(1);
    chk("R3 error one cycle", cfgwr_err, 1'b0);

    // R6: release while idle
    wp_sw_n = 1;
    step(1);
    chk("R6 released when idle", flash_wp_n, 1'b1);

    // R5/R4: request during transfer, then ops pending
    xfer_busy = 1;
    step(1);
    wp_sw_n = 0;
    step(3);
    chk("R5 held during transfer", flash_wp_n, 1'b1);
    cfgwr_req = 1;
    step(1);
    cfgwr_req = 0;
    chk("R4 write allowed while pending", cfgwr_err, 1'b0);
    ops_pending = 1; xfer_busy = 0;
    step(2);
    chk("R5 held while ops pending", flash_wp_n, 1'b1);
    ops_pending = 0;
    step(1);
    chk("R5 applied at first idle", flash_wp_n, 1'b0);

    // R6: release deferred by busy
    ops_pending = 1;
    wp_sw_n = 1;
    step(3);
    chk("R6 held while ops pending", flash_wp_n, 1'b0);
    ops_pending = 0;
    step(1);
    chk("R6 released at idle", flash_wp_n, 1'b1);

    // R5: short switch pulse fully inside a transfer never protects
    xfer_busy = 1;
    wp_sw_n = 0;
    step(2);
    wp_sw_n = 1;
    step(1);
    xfer_busy = 0;
    step(2);
    chk("R5 pulse during busy ignored", flash_wp_n, 1'b1);

    // R7: feature disabled
    wp_enable = 0; wp_sw_n = 0;
    step(3);
    chk("R7 no protect when disabled", flash_wp_n, 1'b1);
    wp_enable = 1;
    step(1);
    chk("R7 protect when re-enabled", flash_wp_n, 1'b0);
    wp_enable = 0;
    step(1);
    chk("R7 disable releases", flash_wp_n, 1'b1);
    wp_enable = 1; wp_sw_n = 1;

    // R8/R9: indicators
    xfer_busy = 1; init_done = 1;
    step(1);
    chk("R8 activity on", act_led_oe, 1'b1);
    chk("R9 ready on", rdy_led_oe, 1'b1);
    xfer_busy = 0; init_done = 0;
    step(1);
    chk("R8 activity off", act_led_oe, 1'b0);
    chk("R9 ready off", rdy_led_oe, 1'b0);

    // pseudo-random phase against the model (R1..R9)
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'd0) wp_sw_n = ~wp_sw_n;
      if (lfsr[7:4] == 4'd0) wp_enable = ~wp_enable;
      xfer_busy   = lfsr[8] & lfsr[9];
      ops_pending = lfsr[10] & lfsr[11] & lfsr[12];
      cfgwr_req   = lfsr[13];
      if (lfsr[15:14] == 2'd3) init_done = ~init_done;
      step(1);
    end

    // R10: asynchronous reset mid-run clears protection
    wp_enable = 1; wp_sw_n = 0; xfer_busy = 0; ops_pending = 0;
    step(2);
    cmp_en = 1'b0;
    rst_n = 0;
    #0.5;
    chk("R10 async reset clears", flash_wp_n, 1'b1);
    finish_run();
  end
endmodule